// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Servicer

This block turns a bank of interrupt input lines into a stream of delivery requests. Each pin has a configuration entry, which an outside register block holds. The entry gives a vector, a destination, a trigger mode and a mask. The servicer tracks each line and decides when a pin should be delivered.

Edge-mode pins fire on a rising line. A second edge that arrives while the first is still waiting is merged into it. Level-mode pins fire only when their remote-IRR bit is clear. The remote-IRR bit is set once the delivery is accepted. An end-of-interrupt (EOI) broadcast that names the pin's vector clears the bit and, if the line is still high, serves the pin again.

Each pin counts its back-to-back EOI re-deliveries. When the count reaches a limit, the re-delivery is deferred by a timer. When the timer expires, every eligible level pin is swept up and served.

Deliveries leave through a valid/ready stream. The lowest-numbered ready pin goes first, and exactly one pin is sent per handshake. Once `out_valid` is raised, the pin, vector, destination and mode stay frozen until `out_ready` is seen high at a clock edge. A stalled consumer therefore holds back every other pin. Further edges on a waiting edge-mode pin merge into its pending request.

Top module: `pin_servicer`

## Requirements
- R1: A level-mode pin whose line falls before its request is taken by the output stage is dropped and never delivered.
- R2: A rising edge on an edge-mode pin whose request is still pending (not yet taken by the output stage) is merged into that request, so only one delivery results.
- R3: A level-mode pin whose remote-IRR bit is set is not delivered when its line rises again.
- R4: A pin whose mask bit is 1 is never delivered. An attempt made while it is masked is lost, and a later delivery needs a new trigger such as an entry-change pulse.
- R5: Accepting a level-mode delivery (`out_valid` and `out_ready` high at a clock edge with `out_level` = 1) sets `remote_irr` for that pin at that edge.
- R6: An EOI whose vector equals a level-mode pin's vector clears that pin's `remote_irr`. If the pin is unmasked and its line is high, the pin is delivered again.
- R7: Each pin counts its consecutive EOI re-deliveries. The EOI that would bring the count to STORM_LIMIT clears `remote_irr` but starts a DEFER_CYCLES timer instead of delivering, and resets the count. An EOI that finds the pin masked or its line low also resets the count.
- R8: When the timer expires, every level-mode pin that is unmasked, has its line high and has `remote_irr` clear is queued for delivery.
- R9: An entry-change pulse for a level-mode pin that is unmasked, has its line high and has `remote_irr` clear triggers a delivery.
- R10: When several pins are ready, the lowest index is presented first. `out_pin`, `out_vector`, `out_dest` and `out_level` stay stable while `out_valid` is high and `out_ready` is low.
- R11: After reset, `out_valid` is 0 and every `remote_irr` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NUM_PINS | Current level of each interrupt line |
| entry_vector | input | NUM_PINS*VEC_W | Vector of each pin; pin i uses bits [i*VEC_W +: VEC_W] |
| entry_dest | input | NUM_PINS*DEST_W | Destination of each pin, laid out the same way |
| entry_level | input | NUM_PINS | Trigger mode: 1 = level, 0 = edge |
| entry_mask | input | NUM_PINS | 1 = pin masked |
| entry_chg_valid | input | 1 | Pulse: the entry named by entry_chg_pin was rewritten |
| entry_chg_pin | input | PIN_W | Index of the rewritten entry |
| eoi_valid | input | 1 | Pulse: EOI broadcast |
| eoi_vector | input | VEC_W | Vector named by the EOI |
| out_valid | output | 1 | A delivery request is presented |
| out_ready | input | 1 | The consumer accepts the request |
| out_pin | output | PIN_W | Pin being delivered |
| out_vector | output | VEC_W | Vector to deliver |
| out_dest | output | DEST_W | Destination to deliver to |
| out_level | output | 1 | 1 if the delivery is level-mode |
| remote_irr | output | NUM_PINS | Remote-IRR bit of each pin |

## Verification
The per-pin state consists of the pending request, the remote-IRR bit, the storm count and the line history. A fault in this state shows at the ports within two or three cycles. It appears either as an extra or missing `out_valid` for that pin, or as a wrong bit in `remote_irr`, which is visible on every cycle. A storm count that is off by one shows only when the limit is reached, as a delivery that should have been deferred. A fault in the shared timer shows as a sweep delivery that arrives on the wrong cycle. Because of this, the bench compares the whole output stream and `remote_irr` against a reference model on every clock.

// File: rtl/ps_pkg.sv
package ps_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/ps_lane.sv
module ps_lane
  import ps_pkg::*;
#(
  parameter int STORM_LIMIT = 10000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line,
  input  logic  mask,
  input  trig_e mode,
  input  logic  vec_hit,
  input  logic  busy,
  input  logic  load,
  input  logic  hs_lvl,
  input  logic  expire,
  input  logic  chg,
  output logic  due,
  output logic  rirr,
  output logic  defer_req
);
  localparam int CW = $clog2(STORM_LIMIT + 1);

  logic          line_q, rirr_q, due_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          lvl, rise, eoi_hit, storm, set_edge, set_lvl;

  assign lvl      = (mode == TRIG_LEVEL);
  assign rise     = line & ~line_q;
  assign eoi_hit  = vec_hit & lvl;
  assign cnt_inc  = cnt_q + 1'b1;
  assign storm    = eoi_hit & ~mask & line & (cnt_inc == CW'(STORM_LIMIT));
  assign set_edge = ~lvl & ~mask & rise;
  assign set_lvl  = lvl & ~mask & line & ~busy &
                    ((rise & ~rirr_q) | (eoi_hit & ~storm) | ((expire | chg) & ~rirr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      rirr_q <= 1'b0;
      due_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      line_q <= line;
      if (set_edge | set_lvl)               due_q <= 1'b1;
      else if (mask | (lvl & ~line) | load) due_q <= 1'b0;
      if (hs_lvl)       rirr_q <= 1'b1;
      else if (eoi_hit) rirr_q <= 1'b0;
      if (eoi_hit) begin
        if (~mask & line) cnt_q <= storm ? '0 : cnt_inc;
        else              cnt_q <= '0;
      end
    end
  end

  assign due       = due_q;
  assign rirr      = rirr_q;
  assign defer_req = storm;
endmodule

// File: rtl/ps_pick.sv
module ps_pick #(
  parameter int N  = 24,
  parameter int PW = 5
) (
  input  logic [N-1:0]  req,
  output logic [PW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = PW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps_defer.sv
module ps_defer #(
  parameter int DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int TW = $clog2(DELAY + 1);

  logic          act_q;
  logic [TW-1:0] tc_q;

  assign expire = act_q & (tc_q == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      tc_q  <= '0;
    end else if (start & (~act_q | expire)) begin
      act_q <= 1'b1;
      tc_q  <= TW'(DELAY);
    end else if (act_q) begin
      if (expire) act_q <= 1'b0;
      else        tc_q  <= tc_q - 1'b1;
    end
  end
endmodule

// File: rtl/pin_servicer.sv
module pin_servicer
  import ps_pkg::*;
#(
  parameter int  NUM_PINS     = 24,
  parameter int  VEC_W        = 8,
  parameter int  DEST_W       = 8,
  parameter int  STORM_LIMIT  = 10000,
  parameter int  DEFER_CYCLES = 1000,
  localparam int PIN_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_level,
  input  logic [NUM_PINS*VEC_W-1:0]  entry_vector,
  input  logic [NUM_PINS*DEST_W-1:0] entry_dest,
  input  logic [NUM_PINS-1:0]        entry_level,
  input  logic [NUM_PINS-1:0]        entry_mask,
  input  logic                       entry_chg_valid,
  input  logic [PIN_W-1:0]           entry_chg_pin,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vector,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PIN_W-1:0]           out_pin,
  output logic [VEC_W-1:0]           out_vector,
  output logic [DEST_W-1:0]          out_dest,
  output logic                       out_level,
  output logic [NUM_PINS-1:0]        remote_irr
);
  logic [NUM_PINS-1:0] due, defer_req, cand;
  logic [PIN_W-1:0]    pick_idx;
  logic                pick_any, take, expire;

  assign cand = due & ~entry_mask;
  assign take = ~out_valid | out_ready;

  ps_pick #(.N(NUM_PINS), .PW(PIN_W)) u_pick (
    .req(cand), .idx(pick_idx), .any(pick_any)
  );

  ps_defer #(.DELAY(DEFER_CYCLES)) u_defer (
    .clk(clk), .rst_n(rst_n), .start(|defer_req), .expire(expire)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    logic occ, ld;
    assign occ = out_valid & (out_pin == PIN_W'(i));
    assign ld  = take & pick_any & (pick_idx == PIN_W'(i));

    ps_lane #(.STORM_LIMIT(STORM_LIMIT)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (pin_level[i]),
      .mask      (entry_mask[i]),
      .mode      (trig_e'(entry_level[i])),
      .vec_hit   (eoi_valid & (entry_vector[i*VEC_W +: VEC_W] == eoi_vector)),
      .busy      (occ | ld),
      .load      (ld),
      .hs_lvl    (occ & out_ready & out_level),
      .expire    (expire),
      .chg       (entry_chg_valid & (entry_chg_pin == PIN_W'(i))),
      .due       (due[i]),
      .rirr      (remote_irr[i]),
      .defer_req (defer_req[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_pin    <= '0;
      out_vector <= '0;
      out_dest   <= '0;
      out_level  <= 1'b0;
    end else if (take) begin
      out_valid <= pick_any;
      if (pick_any) begin
        out_pin    <= pick_idx;
        out_vector <= entry_vector[pick_idx*VEC_W +: VEC_W];
        out_dest   <= entry_dest[pick_idx*DEST_W +: DEST_W];
        out_level  <= entry_level[pick_idx];
      end
    end
  end
endmodule

// File: rtl/ps_chk.sv
module ps_chk #(
  parameter int  NUM_PINS = 24,
  parameter int  VEC_W    = 8,
  parameter int  DEST_W   = 8,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [PIN_W-1:0]    out_pin,
  input logic [VEC_W-1:0]    out_vector,
  input logic [DEST_W-1:0]   out_dest,
  input logic                out_level,
  input logic [NUM_PINS-1:0] entry_mask,
  input logic [NUM_PINS-1:0] remote_irr
);
  logic                valid_q, ready_q, lvl_hs_q;
  logic [PIN_W-1:0]    hs_pin_q;
  logic [NUM_PINS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      ready_q  <= 1'b0;
      lvl_hs_q <= 1'b0;
      hs_pin_q <= '0;
      mask_q   <= '1;
    end else begin
      valid_q  <= out_valid;
      ready_q  <= out_ready;
      lvl_hs_q <= out_valid & out_ready & out_level;
      hs_pin_q <= out_pin;
      mask_q   <= entry_mask;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pin) && $stable(out_vector)
                               && $stable(out_dest) && $stable(out_level));

  assert_pin_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_pin) < NUM_PINS);

  assert_rirr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hs_q |-> remote_irr[hs_pin_q]);

  assert_level_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_level |-> !remote_irr[out_pin]);

  assert_no_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (!valid_q || ready_q) |-> !mask_q[out_pin]);
endmodule

bind pin_servicer ps_chk #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_pin(out_pin), .out_vector(out_vector), .out_dest(out_dest),
  .out_level(out_level), .entry_mask(entry_mask), .remote_irr(remote_irr)
);

// File: tb/tb_pin_servicer.sv
`timescale 1ns/1ps
module tb_pin_servicer;
  localparam int N   = 24;
  localparam int VW  = 8;
  localparam int DW  = 8;
  localparam int LIM = 4;
  localparam int DEF = 12;
  localparam int PW  = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    pin_level, entry_level, entry_mask, remote_irr;
  logic [N*VW-1:0] entry_vector;
  logic [N*DW-1:0] entry_dest;
  logic            entry_chg_valid, eoi_valid, out_valid, out_ready, out_level;
  logic [PW-1:0]   entry_chg_pin, out_pin;
  logic [VW-1:0]   eoi_vector, out_vector;
  logic [DW-1:0]   out_dest;

  always #10 clk = ~clk;

  pin_servicer #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW),
                 .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .entry_vector(entry_vector),
    .entry_dest(entry_dest), .entry_level(entry_level), .entry_mask(entry_mask),
    .entry_chg_valid(entry_chg_valid), .entry_chg_pin(entry_chg_pin),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .out_valid(out_valid),
    .out_ready(out_ready), .out_pin(out_pin), .out_vector(out_vector),
    .out_dest(out_dest), .out_level(out_level), .remote_irr(remote_irr)
  );

  int tests = 0, fails = 0, cycles = 0, last_hs = -1;
  int hs_cnt [N];
  bit done = 0;

  // behavioural reference model
  bit m_irr[N], m_rirr[N], m_due[N];
  int m_cnt[N];
  bit m_ov, m_olvl, m_act;
  int m_op, m_tc;
  logic [VW-1:0] m_ovec;
  logic [DW-1:0] m_odst;
  logic [N-1:0]  m_rirr_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_irr[i] = 0; m_rirr[i] = 0; m_due[i] = 0; m_cnt[i] = 0;
      end
      m_ov = 0; m_olvl = 0; m_act = 0; m_op = 0; m_tc = 0; m_ovec = 0; m_odst = 0;
    end else begin
      bit take, exp_now, start;
      int sel;
      take = !m_ov || out_ready;
      sel = -1;
      for (int i = N - 1; i >= 0; i--) if (m_due[i] && !entry_mask[i]) sel = i;
      exp_now = m_act && (m_tc == 1);
      start = 0;
      for (int i = 0; i < N; i++) begin
        bit ld, occ, lv, mk, lm, rise, eh, storm, chg, setb;
        ld    = take && (sel == i);
        occ   = m_ov && (m_op == i);
        lv    = pin_level[i]; mk = entry_mask[i]; lm = entry_level[i];
        rise  = lv && !m_irr[i];
        eh    = eoi_valid && lm && (entry_vector[i*VW +: VW] == eoi_vector);
        storm = eh && !mk && lv && (m_cnt[i] + 1 == LIM);
        chg   = entry_chg_valid && (int'(entry_chg_pin) == i);
        setb  = (!lm && !mk && rise) ||
                (lm && !mk && lv && !occ && !ld &&
                 ((rise && !m_rirr[i]) || (eh && !storm) || ((exp_now || chg) && !m_rirr[i])));
        if (setb) m_due[i] = 1;
        else if (mk || (lm && !lv) || ld) m_due[i] = 0;
        if (occ && out_ready && m_olvl) m_rirr[i] = 1;
        else if (eh) m_rirr[i] = 0;
        if (eh) m_cnt[i] = (!mk && lv) ? (storm ? 0 : m_cnt[i] + 1) : 0;
        if (storm) start = 1;
        m_irr[i] = lv;
      end
      if (start && (!m_act || exp_now)) begin m_act = 1; m_tc = DEF; end
      else if (m_act) begin if (exp_now) m_act = 0; else m_tc = m_tc - 1; end
      if (take) begin
        m_ov = (sel >= 0);
        if (sel >= 0) begin
          m_op = sel; m_ovec = entry_vector[sel*VW +: VW];
          m_odst = entry_dest[sel*DW +: DW]; m_olvl = entry_level[sel];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: samples 15 ns after each rising edge, inputs change 2 ns after it
  always begin
    @(posedge clk); #15;
    if (rst_n && !done) begin
      bit ok;
      cycles++;
      for (int i = 0; i < N; i++) m_rirr_v[i] = m_rirr[i];
      ok = (out_valid == m_ov) && (remote_irr == m_rirr_v) &&
           (!m_ov || (int'(out_pin) == m_op && out_vector == m_ovec &&
                      out_dest == m_odst && out_level == m_olvl));
      chk(ok, "R10 model", {out_valid, out_pin, remote_irr}, {m_ov, m_op[PW-1:0], m_rirr_v});
      if (out_valid && out_ready) begin
        hs_cnt[out_pin]++;
        last_hs = out_pin;
      end
      if (cycles > 20000) begin
        chk(0, "watchdog", cycles, 20000);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic eoi(input logic [VW-1:0] v);
    eoi_vector = v; eoi_valid = 1; tick(1); eoi_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) hs_cnt[i] = 0;
    pin_level = '0; entry_mask = '1; entry_level = '0;
    entry_level[3] = 1; entry_level[5] = 1; entry_level[7] = 1; entry_level[11] = 1;
    for (int i = 0; i < N; i++) begin
      entry_vector[i*VW +: VW] = VW'(8'h20 + i);
      entry_dest[i*DW +: DW]   = DW'(8'h80 + i);
    end
    entry_chg_valid = 0; entry_chg_pin = '0; eoi_valid = 0; eoi_vector = '0;
    out_ready = 0; rst_n = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    tick(2);
    chk(out_valid == 0 && remote_irr == 0, "R11", {out_valid, remote_irr}, 0);

    // R2: edges on pin 1 merge while output stage is held by pin 0
    entry_mask[0] = 0; entry_mask[1] = 0; pin_level[0] = 1; tick(4);
    pin_level[1] = 1; tick(1); pin_level[1] = 0; tick(1); pin_level[1] = 1; tick(2);
    out_ready = 1; tick(8);
    chk(hs_cnt[1] == 1, "R2", hs_cnt[1], 1);

    // R1: level pin 3 pulses while output stage busy
    out_ready = 0; entry_mask[2] = 0; entry_mask[3] = 0; pin_level[2] = 1; tick(4);
    pin_level[3] = 1; tick(1); pin_level[3] = 0; tick(2);
    out_ready = 1; tick(8);
    chk(hs_cnt[3] == 0, "R1", hs_cnt[3], 0);
    chk(hs_cnt[2] == 1, "R1 edge pin", hs_cnt[2], 1);

    // R5 / R3
    entry_mask[5] = 0; pin_level[5] = 1; tick(6);
    chk(hs_cnt[5] == 1, "R5 delivered", hs_cnt[5], 1);
    chk(remote_irr[5] == 1, "R5", remote_irr[5], 1);
    pin_level[5] = 0; tick(2); pin_level[5] = 1; tick(6);
    chk(hs_cnt[5] == 1, "R3", hs_cnt[5], 1);

    // R6
    eoi(8'h25); tick(6);
    chk(hs_cnt[5] == 2 && remote_irr[5] == 1, "R6", hs_cnt[5], 2);

    // R7 / R8: pin 7 becomes eligible without any trigger
    pin_level[7] = 1; tick(2); entry_mask[7] = 0; tick(2);
    eoi(8'h25); tick(6);
    eoi(8'h25); tick(6);
    chk(hs_cnt[5] == 4, "R7 count", hs_cnt[5], 4);
    eoi(8'h25); tick(4);
    chk(hs_cnt[5] == 4 && remote_irr[5] == 0, "R7 deferred", hs_cnt[5], 4);
    chk(hs_cnt[7] == 0, "R7 pin7 idle", hs_cnt[7], 0);
    tick(DEF + 6);
    chk(hs_cnt[5] == 5, "R8 pin5", hs_cnt[5], 5);
    chk(hs_cnt[7] == 1, "R8 pin7", hs_cnt[7], 1);

    // R4 / R9
    pin_level[9] = 1; tick(5);
    chk(hs_cnt[9] == 0, "R4 masked edge", hs_cnt[9], 0);
    pin_level[11] = 1; tick(2); entry_mask[11] = 0; tick(5);
    chk(hs_cnt[11] == 0, "R4 masked level", hs_cnt[11], 0);
    entry_chg_pin = 5'd11; entry_chg_valid = 1; tick(1); entry_chg_valid = 0; tick(5);
    chk(hs_cnt[11] == 1, "R9", hs_cnt[11], 1);

    // R10: ordering and hold under back-pressure
    out_ready = 0; entry_mask[12] = 0; entry_mask[14] = 0;
    pin_level[12] = 1; pin_level[14] = 1; tick(4);
    chk(out_valid && out_pin == 12, "R10 lowest first", out_pin, 12);
    tick(3);
    chk(out_valid && out_pin == 12 && out_vector == 8'h2C, "R10 hold", out_vector, 8'h2C);
    out_ready = 1; tick(6);
    chk(hs_cnt[12] == 1 && hs_cnt[14] == 1 && last_hs == 14, "R10 order", last_hs, 14);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule